// File: doc/BRIEF.md
# Configurable Logic Cell with Dual Flip-Flops

This block is one tile of a small programmable fabric. Two 4-input lookup tables, F and G, each compute any function of their own four inputs. A 3-input lookup table, H, combines the F result, the G result and a third signal. A crossbar takes four general control pins and routes them onto the cell's four internal control roles: the H third input, a direct data input, set/reset and clock enable.

Two flip-flops capture one of four sources each: F, G, H or the direct data input. They share one clock line, one clock enable and one set/reset line. Each flip-flop has its own capture edge, its own set-or-reset value, and its own choice of whether the shared enable and set/reset lines are connected to it. Two combinational outputs show either a plain table result or the H result.

The lookup contents arrive on table ports. All selections arrive on one configuration word. Both are held constant while the cell runs. The active-low `rst_n` is expected to be asserted asynchronously and released synchronously by the surrounding reset logic.

Top module: `cfg_logic_cell`

## Requirements
- R1: `x_out` with `cfg[8]`=0 equals `f_table[f_in]`, and `y_out` with `cfg[9]`=0 equals `g_table[g_in]`. Input bit 0 is the least significant address bit.
- R2: With `cfg[8]`=1 (`x_out`) or `cfg[9]`=1 (`y_out`), the output equals `h_table[{h1, G, F}]`, where F and G are the table results and h1 is the routed control role.
- R3: Each role has a 2-bit field: h1 at `cfg[1:0]`, direct data at `cfg[3:2]`, set/reset at `cfg[5:4]`, enable at `cfg[7:6]`. A field value k routes `c_in[k]` onto that role.
- R4: The data source field of flip-flop A is `cfg[11:10]` and that of flip-flop B is `cfg[13:12]`. The codes are 0=F, 1=G, 2=H, 3=direct data. The selected value appears on `qa_out`/`qb_out` after the capturing edge.
- R5: `cfg[14]` (A) or `cfg[15]` (B) set to 1 makes that flip-flop capture on the falling clock edge. Set to 0, it captures on the rising edge.
- R6: When its enable is connected, a flip-flop captures only if the routed enable role is high at the capturing edge. Otherwise it holds its value.
- R7: `cfg[18]` (A) or `cfg[19]` (B) set to 0 leaves the enable unconnected for that flip-flop, which then captures on every edge.
- R8: When set/reset is connected (`cfg[20]` for A, `cfg[21]` for B), a high routed set/reset role forces the flip-flop at once, without waiting for a clock edge. The forced value is `cfg[16]` (A) or `cfg[17]` (B), where 1 means set and 0 means reset. The force holds across clock edges while the role stays high.
- R9: With set/reset unconnected, a high routed set/reset role has no effect on that flip-flop.
- R10: `gsr` high forces both flip-flops at once to their configured set/reset values, and clock edges do not override it. After release the flip-flops capture normally again.
- R11: While `rst_n` is low, both flip-flops hold their configured set/reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock line shared by both flip-flops |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| gsr | input | 1 | Active-high asynchronous global set/reset |
| f_in | input | 4 | Inputs of the F table |
| g_in | input | 4 | Inputs of the G table |
| c_in | input | 4 | General control pins routed by the crossbar |
| f_table | input | 16 | Truth table of F |
| g_table | input | 16 | Truth table of G |
| h_table | input | 8 | Truth table of H, indexed {h1, G, F} |
| cfg | input | 22 | Static configuration word |
| x_out | output | 1 | Combinational output, F or H |
| y_out | output | 1 | Combinational output, G or H |
| qa_out | output | 1 | Registered output of flip-flop A |
| qb_out | output | 1 | Registered output of flip-flop B |

## Verification
A wrong table bit or crossbar route shows on `x_out`/`y_out` in the same cycle as the offending input pattern. Walking every address and every route exposes it at once.

A wrong data select, capture edge or enable decision shows on `qa_out`/`qb_out` after a single capturing edge. For a falling-edge flip-flop this is half a clock period after the edge, before the next rising edge.

A set/reset or global-reset fault shows within a fraction of a cycle, because the force is asynchronous. It shows again when the force is released without a clock edge.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int LUT_K    = 4;
  localparam int H_K      = 3;
  localparam int NUM_CTRL = 4;
  localparam int NUM_ROLE = 4;
  localparam int NUM_FF   = 2;
  localparam int NUM_SRC  = 4;
  localparam int CSEL_W   = $clog2(NUM_CTRL);
  localparam int DSEL_W   = $clog2(NUM_SRC);

  // internal control roles fed by the crossbar
  localparam int ROLE_H1  = 0;
  localparam int ROLE_DIN = 1;
  localparam int ROLE_SR  = 2;
  localparam int ROLE_EC  = 3;

  // configuration word layout
  localparam int XB_LSB    = 0;
  localparam int XB_W      = NUM_ROLE * CSEL_W;
  localparam int XSEL_BIT  = XB_LSB + XB_W;
  localparam int YSEL_BIT  = XSEL_BIT + 1;
  localparam int DSEL_LSB  = YSEL_BIT + 1;
  localparam int FALL_LSB  = DSEL_LSB + NUM_FF * DSEL_W;
  localparam int SETV_LSB  = FALL_LSB + NUM_FF;
  localparam int ECON_LSB  = SETV_LSB + NUM_FF;
  localparam int SRCON_LSB = ECON_LSB + NUM_FF;
  localparam int CFG_W     = SRCON_LSB + NUM_FF;

  typedef enum logic [DSEL_W-1:0] {
    SRC_F   = 2'd0,
    SRC_G   = 2'd1,
    SRC_H   = 2'd2,
    SRC_DIN = 2'd3
  } lc_src_e;
endpackage

// File: rtl/lc_lut.sv
module lc_lut #(
  parameter int K = 4,
  localparam int ENTRIES = 1 << K
) (
  input  logic [ENTRIES-1:0] truth,
  input  logic [K-1:0]       addr,
  output logic               o
);
  always_comb begin
    o = truth[addr];
  end
endmodule

// File: rtl/lc_xbar.sv
module lc_xbar #(
  parameter int N = 4,
  parameter int R = 4,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]    ctrl,
  input  logic [R*SW-1:0] sel,
  output logic [R-1:0]    role
);
  for (genvar r = 0; r < R; r++) begin : g_role
    assign role[r] = ctrl[sel[r*SW +: SW]];
  end
endmodule

// File: rtl/lc_flop.sv
module lc_flop #(
  parameter int NSRC = 4,
  localparam int SW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gsr,
  input  logic            sr,
  input  logic            ec,
  input  logic [NSRC-1:0] src,
  input  logic [SW-1:0]   dsel,
  input  logic            fall_edge,
  input  logic            set_val,
  input  logic            ec_conn,
  input  logic            sr_conn,
  output logic            q
);
  logic clr;
  logic en;
  logic d;
  logic rise_q;
  logic rise_nxt;
  logic fall_q;
  logic fall_nxt;

  // next-state logic: unconnected enable counts as enabled,
  // unconnected set/reset counts as inactive
  always_comb begin
    clr      = !rst_n || gsr || (sr && sr_conn);
    en       = ec || !ec_conn;
    d        = src[dsel];
    rise_nxt = en ? d : rise_q;
    fall_nxt = en ? d : fall_q;
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      rise_q <= set_val;
    end else begin
      rise_q <= rise_nxt;
    end
  end

  always_ff @(negedge clk or posedge clr) begin
    if (clr) begin
      fall_q <= set_val;
    end else begin
      fall_q <= fall_nxt;
    end
  end

  assign q = fall_edge ? fall_q : rise_q;
endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
  import lc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    gsr,
  input  logic [LUT_K-1:0]        f_in,
  input  logic [LUT_K-1:0]        g_in,
  input  logic [NUM_CTRL-1:0]     c_in,
  input  logic [(1<<LUT_K)-1:0]   f_table,
  input  logic [(1<<LUT_K)-1:0]   g_table,
  input  logic [(1<<H_K)-1:0]     h_table,
  input  logic [CFG_W-1:0]        cfg,
  output logic                    x_out,
  output logic                    y_out,
  output logic                    qa_out,
  output logic                    qb_out
);
  logic                f_o;
  logic                g_o;
  logic                h_o;
  logic [NUM_ROLE-1:0] role;
  logic [NUM_SRC-1:0]  src;
  logic [NUM_FF-1:0]   q_ff;

  lc_lut #(.K(LUT_K)) u_f_lut (
    .truth (f_table),
    .addr  (f_in),
    .o     (f_o)
  );

  lc_lut #(.K(LUT_K)) u_g_lut (
    .truth (g_table),
    .addr  (g_in),
    .o     (g_o)
  );

  lc_xbar #(.N(NUM_CTRL), .R(NUM_ROLE)) u_xbar (
    .ctrl (c_in),
    .sel  (cfg[XB_LSB +: XB_W]),
    .role (role)
  );

  lc_lut #(.K(H_K)) u_h_lut (
    .truth (h_table),
    .addr  ({role[ROLE_H1], g_o, f_o}),
    .o     (h_o)
  );

  always_comb begin
    x_out        = cfg[XSEL_BIT] ? h_o : f_o;
    y_out        = cfg[YSEL_BIT] ? h_o : g_o;
    src          = '0;
    src[SRC_F]   = f_o;
    src[SRC_G]   = g_o;
    src[SRC_H]   = h_o;
    src[SRC_DIN] = role[ROLE_DIN];
  end

  for (genvar i = 0; i < NUM_FF; i++) begin : g_ff
    lc_flop #(.NSRC(NUM_SRC)) u_ff (
      .clk       (clk),
      .rst_n     (rst_n),
      .gsr       (gsr),
      .sr        (role[ROLE_SR]),
      .ec        (role[ROLE_EC]),
      .src       (src),
      .dsel      (cfg[DSEL_LSB + i*DSEL_W +: DSEL_W]),
      .fall_edge (cfg[FALL_LSB + i]),
      .set_val   (cfg[SETV_LSB + i]),
      .ec_conn   (cfg[ECON_LSB + i]),
      .sr_conn   (cfg[SRCON_LSB + i]),
      .q         (q_ff[i])
    );
  end

  assign qa_out = q_ff[0];
  assign qb_out = q_ff[1];
endmodule

// File: rtl/lc_cell_checker.sv
module lc_cell_checker
  import lc_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                gsr,
  input logic [NUM_CTRL-1:0] c_in,
  input logic [CFG_W-1:0]    cfg,
  input logic                x_out,
  input logic                y_out,
  input logic                qa_out,
  input logic                qb_out
);
  logic ec_line;
  logic sr_line;
  logic clr_a;
  logic en_a;

  always_comb begin
    ec_line = c_in[cfg[XB_LSB + ROLE_EC*CSEL_W +: CSEL_W]];
    sr_line = c_in[cfg[XB_LSB + ROLE_SR*CSEL_W +: CSEL_W]];
    clr_a   = gsr || (sr_line && cfg[SRCON_LSB]);
    en_a    = ec_line || !cfg[ECON_LSB];
  end

  // R11: reset holds the configured values
  p_rst_value_r11: assert property (@(posedge clk)
    !rst_n |-> (qa_out == cfg[SETV_LSB]) && (qb_out == cfg[SETV_LSB+1]));

  // R10: global set/reset wins over the clock
  p_gsr_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gsr |-> (qa_out == cfg[SETV_LSB]) && (qb_out == cfg[SETV_LSB+1]));

  // R8: connected set/reset forces each flip-flop
  p_sr_force_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_line && cfg[SRCON_LSB]) |-> (qa_out == cfg[SETV_LSB]));

  p_sr_force_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_line && cfg[SRCON_LSB+1]) |-> (qb_out == cfg[SETV_LSB+1]));

  // R6: rising-edge flip-flop A holds when its connected enable was low
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(cfg) && !cfg[FALL_LSB] && !clr_a && !$past(clr_a)
     && $past(!en_a)) |-> (qa_out == $past(qa_out)));

  // R4: flip-flop A fed from F captures what x_out showed at the edge
  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(cfg) && !cfg[FALL_LSB] && !cfg[XSEL_BIT]
     && (cfg[DSEL_LSB +: DSEL_W] == SRC_F) && $past(en_a)
     && !clr_a && !$past(clr_a)) |-> (qa_out == $past(x_out)));

  // R2: both outputs on H agree
  p_both_h_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[XSEL_BIT] && cfg[YSEL_BIT]) |-> (x_out == y_out));
endmodule

bind cfg_logic_cell lc_cell_checker i_lc_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .gsr    (gsr),
  .c_in   (c_in),
  .cfg    (cfg),
  .x_out  (x_out),
  .y_out  (y_out),
  .qa_out (qa_out),
  .qb_out (qb_out)
);

// File: tb/test_cfg_logic_cell.sv
`timescale 1ns/1ps
module test_cfg_logic_cell;
  localparam int B_XSEL = 8;
  localparam int B_YSEL = 9;
  localparam int B_DSA  = 10;
  localparam int B_DSB  = 12;
  localparam int B_FALA = 14;
  localparam int B_FALB = 15;
  localparam int B_SETA = 16;
  localparam int B_SETB = 17;
  localparam int B_ECA  = 18;
  localparam int B_ECB  = 19;
  localparam int B_SRA  = 20;
  localparam int B_SRB  = 21;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        gsr;
  logic [3:0]  f_in;
  logic [3:0]  g_in;
  logic [3:0]  c_in;
  logic [15:0] f_table;
  logic [15:0] g_table;
  logic [7:0]  h_table;
  logic [21:0] cfg;
  logic        x_out;
  logic        y_out;
  logic        qa_out;
  logic        qb_out;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  cfg_logic_cell i_cfg_logic_cell (
    .clk     (clk),
    .rst_n   (rst_n),
    .gsr     (gsr),
    .f_in    (f_in),
    .g_in    (g_in),
    .c_in    (c_in),
    .f_table (f_table),
    .g_table (g_table),
    .h_table (h_table),
    .cfg     (cfg),
    .x_out   (x_out),
    .y_out   (y_out),
    .qa_out  (qa_out),
    .qb_out  (qb_out)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    cfg = '0;
    cfg[B_SETA] = 1'b1;
    #1 rst_n = 1'b0;
    #3;
    chk(qa_out, 1'b1, "R11 qa set value");
    chk(qb_out, 1'b0, "R11 qb reset value");
    tick();
    rst_n = 1'b1;
    cfg = '0;
    cfg[B_SETB] = 1'b1;
    tick();
    rst_n = 1'b0;
    #1;
    chk(qa_out, 1'b0, "R11 qa reset value");
    chk(qb_out, 1'b1, "R11 qb set value");
    tick();
    rst_n = 1'b1;
    cfg = '0;
    tick();
  endtask

  task automatic t_lut();
    cfg = '0;
    f_table = 16'hA5C3;
    g_table = 16'h3C96;
    for (int i = 0; i < 16; i++) begin
      f_in = 4'(i);
      g_in = 4'(15 - i);
      #0.5;
      chk(x_out, f_table[i], "R1 F table");
      chk(y_out, g_table[15 - i], "R1 G table");
    end
  endtask

  task automatic t_h();
    cfg = '0;
    cfg[B_XSEL] = 1'b1;
    cfg[B_YSEL] = 1'b1;
    f_table = 16'hFF00;
    g_table = 16'hF0F0;
    h_table = 8'hD2;
    for (int i = 0; i < 8; i++) begin
      f_in = {i[0], 3'b000};
      g_in = {1'b0, i[1], 2'b00};
      c_in = {3'b000, i[2]};
      #0.5;
      chk(x_out, h_table[i], "R2 H via x_out");
      chk(y_out, h_table[i], "R2 H via y_out");
    end
  endtask

  task automatic t_xbar();
    cfg = '0;
    cfg[B_XSEL] = 1'b1;
    h_table = 8'hF0;
    for (int k = 0; k < 4; k++) begin
      cfg[1:0] = 2'(k);
      c_in = 4'(1 << k);
      #0.5;
      chk(x_out, 1'b1, "R3 route high");
      c_in = ~4'(1 << k);
      #0.5;
      chk(x_out, 1'b0, "R3 route low");
    end
  endtask

  task automatic t_dsel();
    logic [3:0] b;
    f_table = 16'hAAAA;
    g_table = 16'hAAAA;
    h_table = 8'hF0;
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 2; v++) begin
        cfg = '0;
        cfg[3:2] = 2'd1;
        cfg[B_DSA +: 2] = 2'(s);
        cfg[B_DSB +: 2] = 2'(s);
        for (int k = 0; k < 4; k++) begin
          b[k] = (k == s) ? v[0] : !v[0];
        end
        f_in = {3'b000, b[0]};
        g_in = {3'b000, b[1]};
        c_in = {2'b00, b[3], b[2]};
        tick();
        chk(qa_out, v[0], "R4 flop A source");
        chk(qb_out, v[0], "R4 flop B source");
      end
    end
  endtask

  task automatic t_edge();
    cfg = '0;
    cfg[B_FALB] = 1'b1;
    f_table = 16'hAAAA;
    c_in = '0;
    f_in = 4'd0;
    tick();
    tick();
    f_in = 4'd1;
    #2;
    chk(qb_out, 1'b1, "R5 falling edge captured");
    chk(qa_out, 1'b0, "R5 rising flop waits");
    tick();
    chk(qa_out, 1'b1, "R5 rising edge captured");
    f_in = 4'd0;
    #2;
    chk(qb_out, 1'b0, "R5 falling edge captured 0");
    chk(qa_out, 1'b1, "R5 rising flop holds");
    tick();
  endtask

  task automatic t_enable();
    cfg = '0;
    cfg[7:6] = 2'd3;
    cfg[B_ECA] = 1'b1;
    cfg[B_ECB] = 1'b1;
    f_table = 16'hAAAA;
    c_in = 4'b1000;
    f_in = 4'd1;
    tick();
    chk(qa_out, 1'b1, "R6 enabled capture A");
    chk(qb_out, 1'b1, "R6 enabled capture B");
    c_in = 4'b0000;
    f_in = 4'd0;
    tick();
    tick();
    chk(qa_out, 1'b1, "R6 hold A");
    chk(qb_out, 1'b1, "R6 hold B");
    c_in = 4'b1000;
    tick();
    chk(qa_out, 1'b0, "R6 re-enabled A");
    c_in = 4'b0000;
    cfg[B_ECA] = 1'b0;
    f_in = 4'd1;
    tick();
    chk(qa_out, 1'b1, "R7 unconnected enable captures");
    chk(qb_out, 1'b0, "R6 connected enable still holds");
  endtask

  task automatic t_sr();
    cfg = '0;
    cfg[5:4] = 2'd2;
    cfg[B_SRA] = 1'b1;
    cfg[B_SRB] = 1'b1;
    cfg[B_SETA] = 1'b1;
    cfg[B_DSB +: 2] = 2'd1;
    f_table = 16'hAAAA;
    g_table = 16'hAAAA;
    c_in = '0;
    f_in = 4'd0;
    g_in = 4'd1;
    tick();
    chk(qa_out, 1'b0, "R8 pre A");
    chk(qb_out, 1'b1, "R8 pre B");
    #1 c_in = 4'b0100;
    #0.5;
    chk(qa_out, 1'b1, "R8 async set A");
    chk(qb_out, 1'b0, "R8 async reset B");
    tick();
    chk(qa_out, 1'b1, "R8 held over edge A");
    chk(qb_out, 1'b0, "R8 held over edge B");
    c_in = 4'b0000;
    #0.5;
    chk(qa_out, 1'b1, "R8 release keeps A");
    tick();
    chk(qa_out, 1'b0, "R8 recapture A");
    chk(qb_out, 1'b1, "R8 recapture B");
    cfg[B_SRA] = 1'b0;
    cfg[B_SRB] = 1'b0;
    c_in = 4'b0100;
    #0.5;
    chk(qa_out, 1'b0, "R9 unconnected sr A");
    chk(qb_out, 1'b1, "R9 unconnected sr B");
    f_in = 4'd1;
    g_in = 4'd0;
    tick();
    chk(qa_out, 1'b1, "R9 capture under sr A");
    chk(qb_out, 1'b0, "R9 capture under sr B");
    c_in = 4'b0000;
    tick();
  endtask

  task automatic t_gsr();
    cfg = '0;
    cfg[B_SETB] = 1'b1;
    cfg[B_DSB +: 2] = 2'd1;
    f_table = 16'hAAAA;
    g_table = 16'hAAAA;
    f_in = 4'd1;
    g_in = 4'd0;
    tick();
    chk(qa_out, 1'b1, "R10 pre A");
    chk(qb_out, 1'b0, "R10 pre B");
    #1 gsr = 1'b1;
    #0.5;
    chk(qa_out, 1'b0, "R10 async A");
    chk(qb_out, 1'b1, "R10 async B");
    tick();
    chk(qa_out, 1'b0, "R10 priority A");
    chk(qb_out, 1'b1, "R10 priority B");
    gsr = 1'b0;
    tick();
    chk(qa_out, 1'b1, "R10 released A");
    chk(qb_out, 1'b0, "R10 released B");
  endtask

  initial begin
    #(200000 * 5);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n   = 1'b1;
    gsr     = 1'b0;
    f_in    = '0;
    g_in    = '0;
    c_in    = '0;
    f_table = '0;
    g_table = '0;
    h_table = '0;
    cfg     = '0;
    t_reset();
    t_lut();
    t_h();
    t_xbar();
    t_dsel();
    t_edge();
    t_enable();
    t_sr();
    t_gsr();
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule